// File: doc/BRIEF.md
# Asynchronous TLB Invalidate Completion Tracker

This block follows, for one hart, how many asynchronous address-translation invalidation requests are still in flight. An invalidation engine pulses `inv_issue` for every request the hart starts and `inv_done` for every request that finishes. The number of requests still open shows up as a read-only busy flag in the supervisor status register. Software can poll this flag. It can also write 1 to a trigger bit in the same register, which asks for a single completion interrupt once the open requests have all finished.

The completion interrupt has a pending bit in the supervisor interrupt-pending register and an enable bit in the supervisor interrupt-enable register. Both sit at bit 12, which matches the interrupt's cause code. The interrupt request line is asserted when the pending bit and the enable bit are both set. Software clears the pending bit by writing 0 to it.

Arming is handled by a two-state machine. ARM_IDLE means no interrupt is requested. ARM_WAIT means a trigger was accepted while requests were open. The transitions are:
- ARM: ARM_IDLE to ARM_WAIT when a trigger arrives, requests are open, and the queue does not drain in that cycle.
- FIRE_NOW: ARM_IDLE to ARM_IDLE, with the pending bit set, when a trigger arrives in the same cycle that the queue drains.
- DROP: ARM_IDLE to ARM_IDLE when a trigger arrives with nothing outstanding.
- FIRE: ARM_WAIT to ARM_IDLE, with the pending bit set, when the queue drains.
- HOLD: ARM_WAIT to ARM_WAIT otherwise.

Top module: `tlbc_tracker`

## Requirements
- R1: After reset, the outstanding count is zero. Every CSR read returns 0, and `busy_o`, `pend_o` and `irq_o` are 0.
- R2: Bit XLEN-2 of the status read (`csr_addr` = 0) and `busy_o` read 1 while the outstanding count is non-zero, and 0 when it is zero. An `inv_issue` or `inv_done` pulse is reflected from the cycle after the clock edge that samples it.
- R3: An `inv_issue` and an `inv_done` in the same cycle leave the count unchanged. An `inv_done` while the count is zero leaves it at zero.
- R4: Writes to status bit XLEN-2 have no effect. Status bit XLEN-3 (the trigger) always reads 0. Writing 0 to the trigger does nothing.
- R5: Writing 1 to the trigger while requests are open arms the tracker. The pending bit is then set at the same clock edge at which the count reaches zero. This includes the case where the trigger is written in the very cycle the last request completes.
- R6: A trigger written while the count is zero is dropped: later requests that issue and drain do not set the pending bit.
- R7: The arm is one-shot. Once the pending bit has been set, further drains do not set it again until a new trigger is accepted.
- R8: The pending bit reads at bit 12 of the interrupt-pending register (`csr_addr` = 1). Writing 0 to bit 12 clears it. Writing 1 to bit 12 has no effect.
- R9: The enable bit is read and written at bit 12 of the interrupt-enable register (`csr_addr` = 2). `irq_o` is 1 exactly when the pending bit and the enable bit are both 1.
- R10: The count saturates at MAX_OUT. Issues at the limit are ignored, so MAX_OUT completions empty the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_issue | input | 1 | One-cycle pulse: an invalidation request was started |
| inv_done | input | 1 | One-cycle pulse: an invalidation request finished |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 2 | Register select: 0 status, 1 interrupt-pending, 2 interrupt-enable, 3 none |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for `csr_addr`, combinational |
| busy_o | output | 1 | Requests outstanding |
| pend_o | output | 1 | Completion interrupt pending |
| irq_o | output | 1 | Completion interrupt request to the hart |

## Verification
Pulses and CSR writes are sampled at a rising edge. The count, the busy flag, the pending bit and the enable bit all change at that edge. `irq_o` and `csr_rdata` follow them in the same cycle with no further register stage. The bench drives each stimulus right after a falling edge. At the next falling edge it queues the expected values of `csr_rdata`, `busy_o` and `irq_o`, and the monitor compares them 1 ns later, one full edge after the stimulus. A bench-side model that follows the requirements supplies the expected values. The drain edge used for R5 therefore comes from the model's count and not from the design.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;

    typedef enum logic [1:0] {
        CSR_STATUS = 2'd0,
        CSR_IP     = 2'd1,
        CSR_IE     = 2'd2,
        CSR_NONE   = 2'd3
    } csr_sel_e;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_WAIT = 1'b1
    } arm_state_e;

    localparam int unsigned CAUSE_TLBI = 12;

endpackage

// File: rtl/tlbc_outstanding.sv
module tlbc_outstanding #(
    parameter int unsigned MAX_OUT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic done_i,
    output logic busy_o,
    output logic drain_o
);
    localparam int unsigned CNT_W = $clog2(MAX_OUT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        cnt_nx = cnt_q;
        if (issue_i && !done_i && (cnt_q != CNT_MAX)) begin
            cnt_nx = cnt_q + 1'b1;
        end else if (done_i && !issue_i && (cnt_q != '0)) begin
            cnt_nx = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nx;
        end
    end

    assign busy_o  = (cnt_q != '0);
    assign drain_o = (cnt_q != '0) && (cnt_nx == '0);

    // R10: saturation at the limit
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) && issue_i && !done_i |=> (cnt_q == CNT_MAX));

    // R3: simultaneous issue and completion hold the count
    p_same_cycle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && done_i |=> (cnt_q == $past(cnt_q)));

    // R3: completion with nothing open keeps the count at zero
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) && done_i && !issue_i |=> (cnt_q == '0));

endmodule

// File: rtl/tlbc_arm_fsm.sv
module tlbc_arm_fsm
    import tlbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic busy_i,
    input  logic drain_i,
    output logic fire_o
);
    arm_state_e state_q;
    arm_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ARM_IDLE: begin
                if (trig_i && busy_i && !drain_i) begin
                    state_nx = ARM_WAIT;
                end
            end
            ARM_WAIT: begin
                if (drain_i) begin
                    state_nx = ARM_IDLE;
                end
            end
            default: state_nx = ARM_IDLE;
        endcase
    end

    always_comb begin
        fire_o = 1'b0;
        unique case (state_q)
            ARM_IDLE: fire_o = trig_i && busy_i && drain_i;
            ARM_WAIT: fire_o = drain_i;
            default:  fire_o = 1'b0;
        endcase
    end

    // R6: a trigger with nothing outstanding is dropped
    p_drop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARM_IDLE) && !busy_i |=> (state_q == ARM_IDLE));

    // R7: after firing, the machine is back in idle
    p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (state_q == ARM_IDLE));

endmodule

// File: rtl/tlbc_csr_file.sv
module tlbc_csr_file
    import tlbc_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [1:0]      addr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            busy_i,
    input  logic            fire_i,
    output logic [XLEN-1:0] rdata_o,
    output logic            trig_o,
    output logic            pend_o,
    output logic            en_o,
    output logic            irq_o
);
    localparam int unsigned BUSY_BIT = XLEN - 2;
    localparam int unsigned TRIG_BIT = XLEN - 3;
    localparam int unsigned IRQ_BIT  = CAUSE_TLBI;

    csr_sel_e sel;
    logic     pend_q;
    logic     en_q;
    logic     clr_pend;
    logic     wr_en;

    assign sel      = csr_sel_e'(addr_i);
    assign trig_o   = we_i && (sel == CSR_STATUS) && wdata_i[TRIG_BIT];
    assign clr_pend = we_i && (sel == CSR_IP) && !wdata_i[IRQ_BIT];
    assign wr_en    = we_i && (sel == CSR_IE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            if (fire_i) begin
                pend_q <= 1'b1;
            end else if (clr_pend) begin
                pend_q <= 1'b0;
            end
            if (wr_en) begin
                en_q <= wdata_i[IRQ_BIT];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            CSR_STATUS: rdata_o[BUSY_BIT] = busy_i;
            CSR_IP:     rdata_o[IRQ_BIT]  = pend_q;
            CSR_IE:     rdata_o[IRQ_BIT]  = en_q;
            CSR_NONE:   rdata_o = '0;
            default:    rdata_o = '0;
        endcase
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign irq_o  = pend_q && en_q;

    // R5: a fire sets the pending bit at that edge
    p_fire_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> pend_o);

    // R8: writing 1 to the pending bit cannot raise it
    p_ip_w1_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q && !fire_i |=> !pend_o);

    // R9: the request line is masked while the enable bit is clear
    p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |-> !irq_o);

endmodule

// File: rtl/tlbc_tracker.sv
module tlbc_tracker
    import tlbc_pkg::*;
#(
    parameter int unsigned XLEN    = 64,
    parameter int unsigned MAX_OUT = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inv_issue,
    input  logic            inv_done,
    input  logic            csr_we,
    input  logic [1:0]      csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            busy_o,
    output logic            pend_o,
    output logic            irq_o
);
    logic busy;
    logic drain;
    logic trig;
    logic fire;
    logic en;

    tlbc_outstanding #(.MAX_OUT(MAX_OUT)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue_i (inv_issue),
        .done_i  (inv_done),
        .busy_o  (busy),
        .drain_o (drain)
    );

    tlbc_arm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig),
        .busy_i  (busy),
        .drain_i (drain),
        .fire_o  (fire)
    );

    tlbc_csr_file #(.XLEN(XLEN)) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (csr_we),
        .addr_i  (csr_addr),
        .wdata_i (csr_wdata),
        .busy_i  (busy),
        .fire_i  (fire),
        .rdata_o (csr_rdata),
        .trig_o  (trig),
        .pend_o  (pend_o),
        .en_o    (en),
        .irq_o   (irq_o)
    );

    assign busy_o = busy;

    // R2: the busy flag only falls on a completion pulse
    p_busy_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !inv_done |=> busy_o);

    // R4: the trigger bit never reads back as 1
    p_trig_reads0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == 2'd0) |-> !csr_rdata[XLEN-3]);

endmodule

// File: tb/tlbc_tracker_test.sv
`timescale 1ns/100ps
module tlbc_tracker_test;
    localparam int unsigned XLEN    = 64;
    localparam int unsigned MAX_OUT = 15;
    localparam int unsigned BUSY_B  = XLEN - 2;
    localparam int unsigned TRIG_B  = XLEN - 3;
    localparam int unsigned IRQ_B   = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            inv_issue = 1'b0;
    logic            inv_done = 1'b0;
    logic            csr_we = 1'b0;
    logic [1:0]      csr_addr = 2'd3;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            busy_o;
    logic            pend_o;
    logic            irq_o;

    always #2.5 clk = ~clk;

    tlbc_tracker #(.XLEN(XLEN), .MAX_OUT(MAX_OUT)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_issue (inv_issue),
        .inv_done  (inv_done),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .busy_o    (busy_o),
        .pend_o    (pend_o),
        .irq_o     (irq_o)
    );

    typedef struct {
        string           tag;
        logic [XLEN-1:0] rd;
        logic            irq;
        logic            busy;
        logic            pend;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int  m_cnt = 0;
    bit  m_armed = 0;
    bit  m_pend = 0;
    bit  m_en = 0;

    task automatic cyc(input logic iss, input logic dn, input logic we,
                       input logic [1:0] a, input logic [XLEN-1:0] wd);
        int  nc;
        bit  trig;
        bit  drain;
        @(negedge clk);
        inv_issue = iss; inv_done = dn; csr_we = we; csr_addr = a; csr_wdata = wd;
        nc = m_cnt;
        if (iss && !dn && m_cnt < MAX_OUT) nc = m_cnt + 1;
        else if (dn && !iss && m_cnt > 0) nc = m_cnt - 1;
        trig  = we && (a == 2'd0) && wd[TRIG_B];
        drain = (m_cnt != 0) && (nc == 0);
        if ((m_armed || (trig && m_cnt != 0)) && drain) begin
            m_pend = 1; m_armed = 0;
        end else begin
            if (trig && m_cnt != 0) m_armed = 1;
            if (we && a == 2'd1 && !wd[IRQ_B]) m_pend = 0;
        end
        if (we && a == 2'd2) m_en = wd[IRQ_B];
        m_cnt = nc;
    endtask

    task automatic chk(input string tag, input logic [1:0] a);
        item_t it;
        @(negedge clk);
        inv_issue = 0; inv_done = 0; csr_we = 0; csr_addr = a; csr_wdata = '0;
        it.tag  = tag;
        it.rd   = '0;
        if (a == 2'd0) it.rd[BUSY_B] = (m_cnt != 0);
        if (a == 2'd1) it.rd[IRQ_B]  = m_pend;
        if (a == 2'd2) it.rd[IRQ_B]  = m_en;
        it.irq  = m_pend && m_en;
        it.busy = (m_cnt != 0);
        it.pend = m_pend;
        q.push_back(it);
    endtask

    task automatic issue_n(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 2'd3, '0);
    endtask
    task automatic done_n(input int n);
        for (int i = 0; i < n; i++) cyc(0, 1, 0, 2'd3, '0);
    endtask
    task automatic wr(input logic [1:0] a, input logic [XLEN-1:0] d);
        cyc(0, 0, 1, a, d);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (csr_rdata !== it.rd || irq_o !== it.irq ||
                    busy_o !== it.busy || pend_o !== it.pend) begin
                    errors++;
                    $display("FAIL %s rdata=%h irq=%b busy=%b pend=%b expected rdata=%h irq=%b busy=%b pend=%b",
                             it.tag, csr_rdata, irq_o, busy_o, pend_o,
                             it.rd, it.irq, it.busy, it.pend);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", 2'd0); chk("R1", 2'd1); chk("R1", 2'd2);
        // R2: busy follows the count
        issue_n(1); chk("R2", 2'd0);
        done_n(1);  chk("R2", 2'd0);
        // R3: simultaneous pulses hold; done on empty stays empty
        issue_n(2); cyc(1, 1, 0, 2'd3, '0);
        done_n(1);  chk("R3", 2'd0);
        done_n(1);  chk("R3", 2'd0);
        done_n(1);  issue_n(1); chk("R3", 2'd0);
        done_n(1);  chk("R3", 2'd0);
        // R4: status writes; trigger reads 0; trigger 0 does not arm
        wr(2'd0, '1); chk("R4", 2'd0); chk("R4", 2'd1);
        issue_n(1);
        d = '0; d[BUSY_B] = 1'b1; wr(2'd0, d); chk("R4", 2'd0);
        done_n(1); chk("R4", 2'd1);
        // R5: armed trigger fires at the drain edge
        issue_n(2);
        d = '0; d[TRIG_B] = 1'b1; wr(2'd0, d);
        done_n(1); chk("R5", 2'd1);
        done_n(1); chk("R5", 2'd1); chk("R5", 2'd0);
        // R9: enable gates the line
        d = '0; d[IRQ_B] = 1'b1; wr(2'd2, d); chk("R9", 2'd2);
        wr(2'd2, '0); chk("R9", 2'd2);
        d = '0; d[IRQ_B] = 1'b1; wr(2'd2, d); chk("R9", 2'd1);
        // R8: write 1 no effect, write 0 clears
        d = '0; d[IRQ_B] = 1'b1; wr(2'd1, d); chk("R8", 2'd1);
        wr(2'd1, '0); chk("R8", 2'd1);
        // R7: no second fire without a new trigger
        issue_n(1); done_n(1); chk("R7", 2'd1);
        // R6: trigger with nothing outstanding is dropped
        d = '0; d[TRIG_B] = 1'b1; wr(2'd0, d);
        issue_n(2); done_n(2); chk("R6", 2'd1);
        // R5: trigger in the same cycle as the last completion
        issue_n(1);
        d = '0; d[TRIG_B] = 1'b1; cyc(0, 1, 1, 2'd0, d);
        chk("R5", 2'd1);
        wr(2'd1, '0); chk("R8", 2'd1);
        // R10: saturation
        issue_n(20); done_n(MAX_OUT - 1); chk("R10", 2'd0);
        done_n(1); chk("R10", 2'd0);
        @(negedge clk); @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule